// File: doc/BRIEF.md
# Frame-Aligned Serial ADC Deserializer

This block turns the serial output lanes of a multi-channel converter back into parallel sample words. The converter sends each lane together with a bit clock and a frame clock. Each lane is sampled on both edges of the bit clock, so two serial bits enter per cycle. The frame clock goes through the same double-edge capture as the data. It is then treated as one more lane that carries a known square pattern. A low-to-high step in the captured frame stream marks the first bit of a new sample. Because two bits arrive per cycle, that step may fall on either bit of the pair, and the block resolves it to the single bit.

Every channel shifts its lanes into a short history register. At each frame boundary, all channels take a word out of that history at the same moment, and one shared strobe is raised. A static mode pin chooses between two layouts. In 1-wire mode the whole sample travels on one lane. In 2-wire mode the sample is split: one lane carries the low half and a second lane carries the high half, each at half the serial length. One bit clock and one frame clock serve all channels.

Top module: `sdes_deserializer`

## Requirements
- R1: While rst_ni is low, and after its release until the first word is emitted, valid_o is 0 and word_o is all zeros.
- R2: Within one bit-clock cycle, the bit sampled on the rising edge comes before the bit sampled on the next falling edge in serial order. The frame pin and every lane pin are captured the same way.
- R3: A word starts at the first serial bit where the captured frame is 1 and the frame bit just before it is 0. This boundary is found whether it lands on the rising-edge bit or the falling-edge bit of a cycle.
- R4: With mode_2w_i = 0, channel c's word is the SAMPLE_W consecutive bits of lane_i[2c]. The first bit received goes to word bit SAMPLE_W-1. lane_i[2c+1] has no effect on the output.
- R5: With mode_2w_i = 1, each frame holds SAMPLE_W/2 bits per lane. lane_i[2c] carries word bits [SAMPLE_W/2-1:0] and lane_i[2c+1] carries bits [SAMPLE_W-1:SAMPLE_W/2], each lane most significant bit first.
- R6: valid_o is a one-cycle pulse, raised once per frame period. All channel fields of word_o change in the same cycle as the pulse and hold their value between pulses.
- R7: The first boundary after reset only sets alignment and emits nothing. Each later boundary emits the word that ended just before it, so N frames that are each followed by a boundary produce exactly N pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; both edges sample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_2w_i | input | 1 | 0: one lane per channel, 1: two lanes per channel; static outside reset |
| frame_i | input | 1 | Frame clock pin, captured like a data lane |
| lane_i | input | 2*NUM_CH | Serial data lanes; lane 2c is the low or only lane of channel c, lane 2c+1 is its high lane |
| word_o | output | NUM_CH*SAMPLE_W | Parallel words; channel c occupies bits [c*SAMPLE_W +: SAMPLE_W] |
| valid_o | output | 1 | One-cycle strobe marking new words on all channels |

## Verification
The assertions assume that the frame stream is a regular square wave once it has locked. Successive low-to-high steps are one lane word apart: SAMPLE_W/2 cycles in 1-wire mode, and alternately one half-cycle short or long in 2-wire mode, where the lane word has an odd length. They also assume that mode_2w_i changes only while reset is held. The stimulus holds frame and lanes low through reset and while idle. It then sends an unbroken run of correctly shaped frames, closed by one extra frame that delivers the final boundary. Mode changes happen only while reset is held. Runs are started with an odd or even number of lead-in bits, so that boundaries fall on both bit positions of a cycle.

// File: rtl/sdes_pkg.sv
package sdes_pkg;
  typedef enum logic [1:0] {
    BND_NONE   = 2'd0,
    BND_FIRST  = 2'd1,  // word starts at rising-edge bit of the pair
    BND_SECOND = 2'd2   // word starts at falling-edge bit of the pair
  } bnd_pos_e;
endpackage

// File: rtl/sdes_ddr_capture.sv
module sdes_ddr_capture #(
  parameter int LANES = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] pin_i,
  output logic [LANES-1:0] first_o,
  output logic [LANES-1:0] second_o
);
  logic [LANES-1:0] rise_q, fall_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) rise_q[l] <= 1'b0;
      else         rise_q[l] <= pin_i[l];

    always_ff @(negedge clk_i or negedge rst_ni)
      if (!rst_ni) fall_q[l] <= 1'b0;
      else         fall_q[l] <= pin_i[l];

    // re-time both halves onto the rising edge as one ordered pair
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        first_o[l]  <= 1'b0;
        second_o[l] <= 1'b0;
      end else begin
        first_o[l]  <= rise_q[l];
        second_o[l] <= fall_q[l];
      end
  end
endmodule

// File: rtl/sdes_frame_detect.sv
module sdes_frame_detect
  import sdes_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     mode_2w_i,
  input  logic     first_i,
  input  logic     second_i,
  output bnd_pos_e pos_o,
  output logic     locked_o
);
  localparam int GAP_W   = $clog2(SAMPLE_W + 2) + 1;
  localparam int GAP_MAX = (1 << GAP_W) - 1;

  logic             prev_q;
  logic             locked_q;
  logic [GAP_W-1:0] gap_q;
  int               lane_bits;

  always_comb begin
    if (!prev_q && first_i)       pos_o = BND_FIRST;
    else if (!first_i && second_i) pos_o = BND_SECOND;
    else                           pos_o = BND_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      prev_q   <= 1'b0;
      locked_q <= 1'b0;
      gap_q    <= '0;
    end else begin
      prev_q <= second_i;
      if (pos_o != BND_NONE) locked_q <= 1'b1;
      if (pos_o != BND_NONE)          gap_q <= '0;
      else if (gap_q != GAP_W'(GAP_MAX)) gap_q <= gap_q + 1'b1;
    end

  assign locked_o  = locked_q;
  assign lane_bits = mode_2w_i ? SAMPLE_W / 2 : SAMPLE_W;

  // boundaries one lane word apart, within half a cycle
  assert_frame_period_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_o != BND_NONE && locked_q) |->
      (2 * (int'(gap_q) + 1) >= lane_bits - 1 && 2 * (int'(gap_q) + 1) <= lane_bits + 1));

  assert_lock_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);
endmodule

// File: rtl/sdes_lane_shifter.sv
module sdes_lane_shifter
  import sdes_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_2w_i,
  input  logic                lo_first_i,
  input  logic                lo_second_i,
  input  logic                hi_first_i,
  input  logic                hi_second_i,
  input  bnd_pos_e            pos_i,
  input  logic                load_i,
  output logic [SAMPLE_W-1:0] word_o
);
  localparam int HALF_W = SAMPLE_W / 2;

  logic [SAMPLE_W-1:0] hist_lo_q;
  logic [HALF_W-1:0]   hist_hi_q;
  logic [SAMPLE_W-1:0] word_q, word_d;
  logic [HALF_W-1:0]   lo_half, hi_half;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hist_lo_q <= '0;
      hist_hi_q <= '0;
    end else begin
      hist_lo_q <= {hist_lo_q[SAMPLE_W-3:0], lo_first_i, lo_second_i};
      hist_hi_q <= {hist_hi_q[HALF_W-3:0], hi_first_i, hi_second_i};
    end

  // a word ending on the first bit of this pair still needs that bit
  always_comb begin
    if (pos_i == BND_SECOND) begin
      lo_half = {hist_lo_q[HALF_W-2:0], lo_first_i};
      hi_half = {hist_hi_q[HALF_W-2:0], hi_first_i};
    end else begin
      lo_half = hist_lo_q[HALF_W-1:0];
      hi_half = hist_hi_q;
    end
    if (mode_2w_i)                word_d = {hi_half, lo_half};
    else if (pos_i == BND_SECOND) word_d = {hist_lo_q[SAMPLE_W-2:0], lo_first_i};
    else                          word_d = hist_lo_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= word_d;

  assign word_o = word_q;

  assert_word_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(word_o));
endmodule

// File: rtl/sdes_deserializer.sv
module sdes_deserializer
  import sdes_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 14
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         mode_2w_i,
  input  logic                         frame_i,
  input  logic [2*NUM_CH-1:0]          lane_i,
  output logic [NUM_CH*SAMPLE_W-1:0]   word_o,
  output logic                         valid_o
);
  localparam int LANES = 2 * NUM_CH + 1;
  localparam int FRM   = LANES - 1;

  logic [LANES-1:0] pins, first, second;
  bnd_pos_e         pos;
  logic             locked, load, valid_q;

  assign pins = {frame_i, lane_i};

  sdes_ddr_capture #(.LANES(LANES)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (pins),
    .first_o  (first),
    .second_o (second)
  );

  sdes_frame_detect #(.SAMPLE_W(SAMPLE_W)) u_frm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_2w_i (mode_2w_i),
    .first_i   (first[FRM]),
    .second_i  (second[FRM]),
    .pos_o     (pos),
    .locked_o  (locked)
  );

  assign load = (pos != BND_NONE) && locked;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sdes_lane_shifter #(.SAMPLE_W(SAMPLE_W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mode_2w_i   (mode_2w_i),
      .lo_first_i  (first[2*c]),
      .lo_second_i (second[2*c]),
      .hi_first_i  (first[2*c+1]),
      .hi_second_i (second[2*c+1]),
      .pos_i       (pos),
      .load_i      (load),
      .word_o      (word_o[c*SAMPLE_W +: SAMPLE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= load;

  assign valid_o = valid_q;

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_word_changes_on_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> valid_o);
endmodule

// File: tb/sdes_deserializer_tb_top.sv
module sdes_deserializer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 4;
  localparam int SAMPLE_W   = 14;
  localparam int HALF_W     = SAMPLE_W / 2;
  localparam int WW         = NUM_CH * SAMPLE_W;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                mode_2w_i = 1'b0;
  logic                frame_i = 1'b0;
  logic [2*NUM_CH-1:0] lane_i = '0;
  logic [WW-1:0]       word_o;
  logic                valid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [WW-1:0]       exp_w [0:63];
  logic                fr_s  [0:4095];
  logic [2*NUM_CH-1:0] ln_s  [0:4095];
  int                  n_bits;
  int                  got;
  bit                  mon_en = 1'b0;
  bit                  prev_v = 1'b0;
  string               mon_req;

  sdes_deserializer #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [SAMPLE_W-1:0] pick(int kind, int f, int c);
    logic [31:0] r;
    r = $urandom;
    case (kind)
      1:       return SAMPLE_W'(f * NUM_CH + c);
      2:       return SAMPLE_W'(1) << ((f + c) % SAMPLE_W);
      3:       return ((f + c) % 2 == 1) ? '1 : '0;
      default: return r[SAMPLE_W-1:0];
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [WW-1:0] act, logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // compare outputs at the falling edge, away from the register updates
  always @(negedge clk_i) begin
    if (mon_en) begin
      if (valid_o) begin
        if (got < 64) check(word_o == exp_w[got], mon_req, word_o, exp_w[got]);
        check(!prev_v, "R6 single pulse", WW'(prev_v), '0);
        got++;
      end else if (got > 0 && got <= 64) begin
        if (word_o != exp_w[got-1]) check(1'b0, "R6 hold", word_o, exp_w[got-1]);
      end else if (got == 0) begin
        if (word_o != '0) check(1'b0, "R1 idle before first word", word_o, '0);
      end
      prev_v = valid_o;
    end
  end

  task automatic run_scn(bit m2w, int offset, int nf, int kind, string req);
    int lb, n;
    logic [31:0] r;
    lb = m2w ? HALF_W : SAMPLE_W;
    for (int f = 0; f < nf; f++)
      for (int c = 0; c < NUM_CH; c++) exp_w[f][c*SAMPLE_W +: SAMPLE_W] = pick(kind, f, c);
    exp_w[nf] = '0;

    // build the serial streams, time order = array order
    n = 0;
    for (int i = 0; i < offset + 4; i++) begin fr_s[n] = 1'b0; ln_s[n] = '0; n++; end
    for (int f = 0; f <= nf; f++)
      for (int j = 0; j < lb; j++) begin
        fr_s[n] = (j < (lb + 1) / 2);
        for (int c = 0; c < NUM_CH; c++) begin
          r = $urandom;
          if (m2w) begin
            ln_s[n][2*c]   = exp_w[f][c*SAMPLE_W + HALF_W - 1 - j];
            ln_s[n][2*c+1] = exp_w[f][c*SAMPLE_W + SAMPLE_W - 1 - j];
          end else begin
            ln_s[n][2*c]   = exp_w[f][c*SAMPLE_W + SAMPLE_W - 1 - j];
            ln_s[n][2*c+1] = r[0];  // R4: high lane is noise in 1-wire mode
          end
        end
        n++;
      end
    for (int i = 0; i < 2 * lb + (n % 2); i++) begin fr_s[n] = 1'b0; ln_s[n] = '0; n++; end
    n_bits = n;

    rst_ni    = 1'b0;
    mode_2w_i = m2w;
    frame_i   = 1'b0;
    lane_i    = '0;
    mon_en    = 1'b0;
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0 && word_o == '0, "R1 reset", {word_o[WW-2:0], valid_o}, '0);
    rst_ni  = 1'b1;
    got     = 0;
    prev_v  = 1'b0;
    mon_req = req;
    mon_en  = 1'b1;

    // rising-edge bit driven after the falling edge, falling-edge bit after the rising edge
    for (int k = 0; k < n_bits; k += 2) begin
      @(negedge clk_i); #2;
      frame_i = fr_s[k];   lane_i = ln_s[k];
      @(posedge clk_i); #2;
      frame_i = fr_s[k+1]; lane_i = ln_s[k+1];
    end
    repeat (6) @(negedge clk_i);
    mon_en = 1'b0;
    check(got == nf, "R7 word count", WW'(got), WW'(nf));
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk_i);
    run_scn(1'b0, 0, 20, 0, "R2 R3 R4 random 1-wire");
    run_scn(1'b0, 1, 16, 1, "R3 R4 ramp 1-wire boundary on falling bit");
    run_scn(1'b0, 3, 12, 3, "R4 all-ones/zeros 1-wire");
    run_scn(1'b1, 0, 20, 0, "R3 R5 random 2-wire");
    run_scn(1'b1, 1, 16, 2, "R5 walking one 2-wire");
    run_scn(1'b1, 2, 12, 1, "R2 R5 ramp 2-wire");
    run_scn(1'b0, 5, 24, 2, "R3 R4 walking one 1-wire odd lead-in");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R6 watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule